// File: doc/BRIEF.md
# Keyed Software Reset Trigger

This block gives software a guarded way to start a warm system reset. A CPU first writes an unlock key to the trigger register. It then programs the control register with a reset request and the scope options. Finally it writes a second, different key to the trigger register. The reset fires only if a request bit is set when that second key arrives. A stray or out-of-order write cannot reset the system.

When the reset fires, the block emits one-cycle request pulses: one for each CPU core whose reset is requested, and one for all peripherals. It also emits a one-cycle cause strobe that names the requesting CPU, for a boot-cause register. The register port is a simple 32-bit write port with a combinational read. The bus decode above the two offsets, the reset synchronizers and the cores themselves sit outside this block.

Top module: `swrst_keyed_trigger`

## Requirements
- R1: After reset the control register reads 0, the trigger register reads 0 (locked), and core_rst, peri_rst and cause are all 0.
- R2: A write to the control register (offset 0x60) while locked leaves its read value unchanged.
- R3: Writing 0x96969696 to the trigger register (offset 0x64) unlocks. While unlocked, the trigger register reads 0x96969696 and control writes take effect. The unlock stays in force across any number of control writes.
- R4: Control bit 31 is CPU A's reset request and bit 30 is CPU B's. Bit 1 adds a reset of all peripherals and bit 0 adds a reset of the other CPU. Bits 29:2 always read 0, whatever was written.
- R5: Any trigger write other than 0x96969696 leaves the block locked, and a locked trigger register reads 0.
- R6: Writing 0x69696969 to the trigger register while bit 31 or bit 30 is set fires the reset, whether or not the block is unlocked. In the cycle after the write edge, each of the following outputs is 1 for exactly one cycle:
  - core_rst[0] (CPU A) when A requested, or when B requested with bit 0 set.
  - core_rst[1] (CPU B) when B requested, or when A requested with bit 0 set.
  - peri_rst when bit 1 is set.
  - cause[0] when A requested, and cause[1] when B requested.
- R7: A firing write clears bits 31:30, keeps bits 1:0 and relocks the block.
- R8: Writing 0x69696969 while bits 31:30 are both 0 produces no pulse on any output and only relocks the block.
- R9: Writes to any other offset change nothing, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Register offset for both read and write |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| core_rst | output | 2 | One-cycle core reset requests, bit 0 CPU A, bit 1 CPU B |
| peri_rst | output | 1 | One-cycle all-peripheral reset request |
| cause | output | 2 | One-cycle cause strobe, bit 0 CPU A requested, bit 1 CPU B requested |

## Verification
A wrong lock flag shows at once on a trigger-register read, which returns 0x96969696 only while unlocked. It shows again on the next control write, whose value either sticks or does not. Corrupt request or scope bits appear on the control read-back immediately. They also appear on the pulse pattern one cycle after the next firing write, when the wrong core, peripheral or cause outputs rise. A pulse that stays high, or request bits that fail to clear, are visible on the cycle after the firing edge.

// File: rtl/swrst_pkg.sv
`timescale 1ns/1ps
// Package: shared keys, field positions and the control register type for
// the keyed software reset trigger. Assumes a 32-bit register port.
package swrst_pkg;
    localparam int DATA_W = 32;
    localparam int NUM_CPU = 2;
    localparam logic [DATA_W-1:0] KEY_UNLOCK = 32'h9696_9696;
    localparam logic [DATA_W-1:0] KEY_FIRE   = 32'h6969_6969;
    localparam int BIT_REQ_A = 31;
    localparam int BIT_REQ_B = 30;
    localparam int BIT_PERI  = 1;
    localparam int BIT_OTHER = 0;

    typedef struct packed {
        logic [NUM_CPU-1:0] req;      // req[0] = CPU A, req[1] = CPU B
        logic               peri_en;
        logic               other_en;
    } ctrl_t;
endpackage

// File: rtl/swrst_key_lock.sv
`timescale 1ns/1ps
// Module: swrst_key_lock
// Tracks the unlock state from trigger-register writes and decodes the fire
// key. Assumes trig_wr is a single-cycle qualified write to the trigger offset.
module swrst_key_lock
    import swrst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked,
    output logic              fire_key
);
    // Fire key decode: valid on any trigger write, locked or not.
    always_comb begin
        fire_key = trig_wr && (wdata == KEY_FIRE);
    end

    // Lock state: only the unlock key unlocks; every other trigger write relocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (trig_wr) begin
            unlocked <= (wdata == KEY_UNLOCK);
        end
    end
endmodule

// File: rtl/swrst_ctrl_reg.sv
`timescale 1ns/1ps
// Module: swrst_ctrl_reg
// Holds the request and scope bits. Loads only while unlocked and clears the
// request bits when a reset is issued. Assumes ctrl_wr and clr_req never
// coincide, because both come from the single write port.
module swrst_ctrl_reg
    import swrst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctrl_wr,
    input  logic  unlocked,
    input  ctrl_t ctrl_d,
    input  logic  clr_req,
    output ctrl_t ctrl_q
);
    // Register update: guarded load, self-clear of requests on fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr && unlocked) begin
            ctrl_q <= ctrl_d;
        end else if (clr_req) begin
            ctrl_q.req <= '0;
        end
    end
endmodule

// File: rtl/swrst_pulse_gen.sv
`timescale 1ns/1ps
// Module: swrst_pulse_gen
// Turns a fire event and the control bits into registered one-cycle reset
// and cause pulses. Assumes fire is high for at most one cycle at a time.
module swrst_pulse_gen
    import swrst_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  ctrl_t              ctrl,
    output logic [NUM_CPU-1:0] core_rst,
    output logic               peri_rst,
    output logic [NUM_CPU-1:0] cause
);
    logic [NUM_CPU-1:0] core_d;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_core
        localparam logic [NUM_CPU-1:0] OTHERS = ~(NUM_CPU'(1) << g);
        // Per-core request: own request, or another CPU's request when the
        // other-CPU scope bit is set.
        always_comb begin
            core_d[g] = fire && (ctrl.req[g] || (ctrl.other_en && |(ctrl.req & OTHERS)));
        end
    end

    // Output pulse registers: high for the single cycle after a fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_rst <= '0;
            peri_rst <= 1'b0;
            cause    <= '0;
        end else begin
            core_rst <= core_d;
            peri_rst <= fire && ctrl.peri_en;
            cause    <= fire ? ctrl.req : '0;
        end
    end
endmodule

// File: rtl/swrst_keyed_trigger.sv
`timescale 1ns/1ps
// Module: swrst_keyed_trigger (top)
// Register-mapped keyed reset trigger with a control and a trigger register.
// Assumes the bus above has already qualified the access to this block;
// offsets not matching either register are ignored.
module swrst_keyed_trigger
    import swrst_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h60,
    parameter logic [ADDR_W-1:0] TRIG_OFS = 'h64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_CPU-1:0] core_rst,
    output logic               peri_rst,
    output logic [NUM_CPU-1:0] cause
);
    logic  ctrl_wr, trig_wr, unlocked_q, fire_key, fire;
    ctrl_t ctrl_d, ctrl_q;

    // Write decode for the two offsets.
    always_comb begin
        ctrl_wr = wr_en && (addr == CTRL_OFS);
        trig_wr = wr_en && (addr == TRIG_OFS);
    end

    // Field extraction from write data into the control type.
    always_comb begin
        ctrl_d.req[0]   = wdata[BIT_REQ_A];
        ctrl_d.req[1]   = wdata[BIT_REQ_B];
        ctrl_d.peri_en  = wdata[BIT_PERI];
        ctrl_d.other_en = wdata[BIT_OTHER];
    end

    // Fire only when the key arrives with at least one request pending.
    always_comb begin
        fire = fire_key && (|ctrl_q.req);
    end

    swrst_key_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_wr  (trig_wr),
        .wdata    (wdata),
        .unlocked (unlocked_q),
        .fire_key (fire_key)
    );

    swrst_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .unlocked (unlocked_q),
        .ctrl_d   (ctrl_d),
        .clr_req  (fire),
        .ctrl_q   (ctrl_q)
    );

    swrst_pulse_gen u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .ctrl     (ctrl_q),
        .core_rst (core_rst),
        .peri_rst (peri_rst),
        .cause    (cause)
    );

    // Read mux: reserved bits zero, trigger shows the unlock key while unlocked.
    always_comb begin
        rd_data = '0;
        if (addr == CTRL_OFS) begin
            rd_data[BIT_REQ_A] = ctrl_q.req[0];
            rd_data[BIT_REQ_B] = ctrl_q.req[1];
            rd_data[BIT_PERI]  = ctrl_q.peri_en;
            rd_data[BIT_OTHER] = ctrl_q.other_en;
        end else if (addr == TRIG_OFS) begin
            rd_data = unlocked_q ? KEY_UNLOCK : '0;
        end
    end
endmodule

// File: rtl/swrst_checker.sv
`timescale 1ns/1ps
// Module: swrst_checker
// Temporal properties for swrst_keyed_trigger, attached by bind. Observes
// ports plus the lock flag and the control register state.
module swrst_checker
    import swrst_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h60,
    parameter logic [ADDR_W-1:0] TRIG_OFS = 'h64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_CPU-1:0] core_rst,
    input logic               peri_rst,
    input logic [NUM_CPU-1:0] cause,
    input logic               unlocked,
    input ctrl_t              ctrl_bits
);
    p_locked_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_OFS && !unlocked) |=> $stable(ctrl_bits));

    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CTRL_OFS) |-> (rd_data[29:2] == '0));

    p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == TRIG_OFS && wdata != KEY_UNLOCK) |=> !unlocked);

    p_cause_needs_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause != '0) |-> $past(wr_en && addr == TRIG_OFS && wdata == KEY_FIRE));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst != '0) |=> (core_rst == '0));

    p_req_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cause != '0) |-> (ctrl_bits.req == '0));

    p_no_req_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == TRIG_OFS && wdata == KEY_FIRE && ctrl_bits.req == '0)
        |=> (core_rst == '0 && !peri_rst && cause == '0));
endmodule

bind swrst_keyed_trigger swrst_checker #(
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .TRIG_OFS (TRIG_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rd_data   (rd_data),
    .core_rst  (core_rst),
    .peri_rst  (peri_rst),
    .cause     (cause),
    .unlocked  (unlocked_q),
    .ctrl_bits (ctrl_q)
);

// File: tb/sim_swrst_keyed_trigger.sv
`timescale 1ns/1ps
module sim_swrst_keyed_trigger;
    localparam logic [7:0]  A_CTRL = 8'h60;
    localparam logic [7:0]  A_TRIG = 8'h64;
    localparam logic [31:0] K_UNL  = 32'h9696_9696;
    localparam logic [31:0] K_FIRE = 32'h6969_6969;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [1:0]  core_rst;
    logic        peri_rst;
    logic [1:0]  cause;

    int total = 0;
    int fails = 0;

    // Bench model state
    logic        m_unl = 1'b0;
    logic [31:0] m_ctrl = '0;

    always #5 clk = ~clk;

    swrst_keyed_trigger u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .core_rst(core_rst), .peri_rst(peri_rst), .cause(cause)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected pulses {core[1:0], peri, cause[1:0]} for a write given model state (R6, R8)
    function automatic logic [4:0] exp_pulse(input logic [7:0] a, input logic [31:0] d,
                                             input logic [31:0] c);
        logic ra, rb, fire;
        ra = c[31];
        rb = c[30];
        fire = (a == A_TRIG) && (d == K_FIRE) && (ra || rb);
        return {fire && (rb || (ra && c[0])), fire && (ra || (rb && c[0])),
                fire && c[1], fire && rb, fire && ra};
    endfunction

    task automatic model_update(input logic [7:0] a, input logic [31:0] d);
        if (a == A_CTRL && m_unl) begin
            m_ctrl = d & 32'hC000_0003;
        end else if (a == A_TRIG) begin
            if (d == K_FIRE && (m_ctrl[31] || m_ctrl[30])) m_ctrl[31:30] = 2'b00;
            m_unl = (d == K_UNL);
        end
    endtask

    task automatic read_back(input string tag);
        addr = A_CTRL;
        #1;
        check({tag, " R4 ctrl readback"}, rd_data, m_ctrl);
        addr = A_TRIG;
        #1;
        check({tag, " R3 R5 trig readback"}, rd_data, m_unl ? K_UNL : 32'h0);
        addr = 8'h10;
        #1;
        check({tag, " R9 other offset read"}, rd_data, 32'h0);
    endtask

    task automatic do_write(input string tag, input logic [7:0] a, input logic [31:0] d);
        logic [4:0] e;
        e = exp_pulse(a, d, m_ctrl);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        check({tag, " R6 R8 pulses"}, {27'h0, core_rst, peri_rst, cause}, {27'h0, e});
        model_update(a, d);
        @(negedge clk);
        check({tag, " R6 single cycle"}, {27'h0, core_rst, peri_rst, cause}, 32'h0);
        read_back(tag);
    endtask

    // Watchdog
    initial begin
        #1ms;
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pulses", {27'h0, core_rst, peri_rst, cause}, 32'h0);
        read_back("R1 reset");

        // Directed corner cases
        do_write("R2 locked ctrl", A_CTRL, 32'hFFFF_FFFF);
        do_write("R3 unlock", A_TRIG, K_UNL);
        do_write("R4 all ones", A_CTRL, 32'hFFFF_FFFF);
        do_write("R3 second ctrl", A_CTRL, 32'h8000_0002);
        do_write("R6 fire A peri", A_TRIG, K_FIRE);
        do_write("R7 after fire ctrl", A_CTRL, 32'h4000_0000);
        do_write("R8 fire no req", A_TRIG, K_FIRE);
        do_write("R3 unlock", A_TRIG, K_UNL);
        do_write("R9 other addr", 8'h68, 32'hC000_0003);
        do_write("R4 B other", A_CTRL, 32'h4000_0001);
        do_write("R5 bad key", A_TRIG, 32'h1234_5678);
        do_write("R6 fire while locked", A_TRIG, K_FIRE);
        do_write("R3 unlock", A_TRIG, K_UNL);
        do_write("R6 both", A_CTRL, 32'hC000_0003);
        do_write("R6 fire both", A_TRIG, K_FIRE);

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] ra;
            op = int'($urandom % 6);
            case (op)
                0, 1: do_write("rand ctrl", A_CTRL, $urandom);
                2:    do_write("rand unlock", A_TRIG, K_UNL);
                3:    do_write("rand fire", A_TRIG, K_FIRE);
                4:    do_write("rand trig", A_TRIG, $urandom);
                default: begin
                    ra = 8'($urandom);
                    if (ra == A_CTRL || ra == A_TRIG) ra = 8'h00;
                    do_write("rand other", ra, $urandom);
                end
            endcase
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule